// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block sits beside a CPU core and decides, at each instruction boundary, which pending interrupt request the core services next. Requests come in two groups. Three sources are non-maskable: a high-priority external pin, an illegal-opcode trap and a software trap. A parameterised set of maskable sources shares the global interrupt mask. Index 0 is the external IRQ pin. The remaining indices are peripheral flags, and each one carries its own local enable.

The block owns the global interrupt mask bit (I), the high-priority pin mask bit (X) and a priority-select register. The priority-select register lifts one chosen maskable source above all other maskable sources. When a request wins, the block pulses a take strobe for one cycle and presents a vector index with it. The core uses that index to fetch the service routine address. The core tells the block about returns from service and explicit mask instructions through single-cycle control inputs. Register stacking and vector fetch belong to the core.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets I=1, X=1, the priority select to 0, `take`=0 and `vec`=0.
- R2: Arbitration takes place only at an edge where `boundary`=1. The winner appears on the next cycle as `take`=1 together with its nonzero `vec`, held for exactly that cycle. In every other cycle `take`=0 and `vec`=0.
- R3: The non-maskable sources rank above all maskable ones. Among themselves the order is high-priority pin (vector 1), then illegal opcode (vector 2), then software trap (vector 3).
- R4: The high-priority pin is ignored while X=1. A level that is still present wins once X is 0.
- R5: The illegal-opcode and software traps are taken even while both I and X are 1.
- R6: No maskable source is taken while I=1. A request that stays asserted is taken at the first boundary after I returns to 0.
- R7: Maskable source k is pending only when `src_flag[k]` and `src_en[k]` are both 1. Its vector is 4+k.
- R8: Without promotion, the lowest-indexed pending maskable source wins.
- R9: If the priority select holds a value p below N_SRC and source p is pending, source p wins over every other maskable source. A value of N_SRC or more promotes nothing.
- R10: A `psel_wr` pulse loads `psel_data` only when I=1 at that edge. When I=0 the write is ignored.
- R11: I is updated in this order of precedence: a take sets it to 1, then `rti` loads `rti_i`, then `set_i` sets it to 1, then `clr_i` clears it.
- R12: X becomes 1 only through reset or on taking vector 1. `clr_x` clears X. `rti` loads X AND `rti_x`, so a return can never set X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Core is at an instruction boundary |
| hp_req | input | 1 | High-priority external pin request (level) |
| illop_req | input | 1 | Illegal opcode trap request |
| swtrap_req | input | 1 | Software trap request |
| src_flag | input | N_SRC | Maskable source flags, index 0 = IRQ pin |
| src_en | input | N_SRC | Local enables for the maskable sources |
| rti | input | 1 | Return-from-interrupt pulse |
| rti_i | input | 1 | I value restored by the return |
| rti_x | input | 1 | X value restored by the return (can only clear) |
| set_i | input | 1 | Explicit set of I |
| clr_i | input | 1 | Explicit clear of I |
| clr_x | input | 1 | Explicit clear of X |
| psel_wr | input | 1 | Write strobe for the priority select |
| psel_data | input | PSW | Priority select value to write |
| take | output | 1 | Take-interrupt strobe |
| vec | output | VECW | Vector index of the winner, 0 when idle |
| i_mask | output | 1 | Global interrupt mask bit |
| x_mask | output | 1 | High-priority pin mask bit |

## Verification
The priority select is the hardest state to observe. It can only be loaded in the window where I is 1, and its effect only shows once I has been cleared and a maskable request wins. The stimulus therefore sets I, writes the select, and clears I. It then tries a second write with I clear. Finally it presents several pending sources so that the winning vector shows which of the two writes took effect. The X bit gets a similar treatment. The bench clears X, then issues a return carrying an X value of 1, and confirms that X stays clear.

// File: rtl/irq_arb_pkg.sv
// Shared vector encodings for the interrupt arbiter.
// Assumes vector 0 means "no interrupt" and that the maskable vectors start after the traps.
package irq_arb_pkg;
    localparam int VEC_NONE  = 0;
    localparam int VEC_HP    = 1;
    localparam int VEC_ILL   = 2;
    localparam int VEC_SWT   = 3;
    localparam int VEC_MBASE = 4;
endpackage

// File: rtl/irq_nm_pick.sv
// Fixed-order picker for the non-maskable sources.
// Assumes the high-priority pin is gated by X and that the traps ignore every mask.
module irq_nm_pick
    import irq_arb_pkg::*;
#(
    parameter int VECW = 5
) (
    input  logic            hp_req,
    input  logic            x_mask,
    input  logic            illop_req,
    input  logic            swtrap_req,
    output logic            hit,
    output logic [VECW-1:0] code
);
    // Select the highest ranked non-maskable request.
    always_comb begin
        hit  = 1'b1;
        code = VECW'(VEC_NONE);
        if (hp_req && !x_mask)  code = VECW'(VEC_HP);
        else if (illop_req)     code = VECW'(VEC_ILL);
        else if (swtrap_req)    code = VECW'(VEC_SWT);
        else                    hit  = 1'b0;
    end
endmodule

// File: rtl/irq_mask_pick.sv
// Priority picker for the maskable sources, with single-source promotion.
// Assumes N_SRC <= 2**PSW. A select value with no matching source promotes nothing.
module irq_mask_pick #(
    parameter int N_SRC = 13,
    parameter int PSW   = 4,
    parameter int IDXW  = 4
) (
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] en,
    input  logic             blocked,
    input  logic [PSW-1:0]   psel,
    output logic             hit,
    output logic [IDXW-1:0]  idx
);
    localparam int PADW = 1 << PSW;

    logic [N_SRC-1:0] pend;
    logic [PADW-1:0]  pend_pad;

    // A source pends only when its flag and enable are both set and I is clear.
    for (genvar g = 0; g < N_SRC; g++) begin : g_pend
        assign pend[g] = flag[g] & en[g] & ~blocked;
    end

    assign pend_pad = PADW'(pend);

    // Promoted source first, otherwise the lowest index wins.
    always_comb begin
        hit = |pend;
        idx = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (pend[k]) idx = IDXW'(k);
        end
        if (pend_pad[psel]) idx = IDXW'(psel);
    end
endmodule

// File: rtl/irq_ccr_regs.sv
// Holds the I and X mask bits and the priority-select register.
// Assumes the control pulses last one cycle. Only reset and a take of the pin vector can set X.
module irq_ccr_regs #(
    parameter int PSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take_now,
    input  logic           take_hp,
    input  logic           rti,
    input  logic           rti_i,
    input  logic           rti_x,
    input  logic           set_i,
    input  logic           clr_i,
    input  logic           clr_x,
    input  logic           psel_wr,
    input  logic [PSW-1:0] psel_data,
    output logic           i_q,
    output logic           x_q,
    output logic [PSW-1:0] psel_q
);
    // Global mask: entry, then return, then explicit set, then explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        i_q <= 1'b1;
        else if (take_now) i_q <= 1'b1;
        else if (rti)      i_q <= rti_i;
        else if (set_i)    i_q <= 1'b1;
        else if (clr_i)    i_q <= 1'b0;
    end

    // Pin mask: hardware sets it, software and returns may only clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)       x_q <= 1'b1;
        else if (take_hp) x_q <= 1'b1;
        else if (rti)     x_q <= x_q & rti_x;
        else if (clr_x)   x_q <= 1'b0;
    end

    // Priority select accepts writes only while I is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                psel_q <= '0;
        else if (psel_wr && i_q)   psel_q <= psel_data;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Top of the interrupt arbiter. Combines the two pickers, registers the winner
// at an instruction boundary, and updates the mask bits.
// Assumes the core samples take/vec one cycle after it raised boundary.
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 13,
    parameter int PSW   = 4,
    parameter int VECW  = $clog2(N_SRC + VEC_MBASE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             hp_req,
    input  logic             illop_req,
    input  logic             swtrap_req,
    input  logic [N_SRC-1:0] src_flag,
    input  logic [N_SRC-1:0] src_en,
    input  logic             rti,
    input  logic             rti_i,
    input  logic             rti_x,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             clr_x,
    input  logic             psel_wr,
    input  logic [PSW-1:0]   psel_data,
    output logic             take,
    output logic [VECW-1:0]  vec,
    output logic             i_mask,
    output logic             x_mask
);
    localparam int IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic            nm_hit, m_hit, take_now, take_hp;
    logic [VECW-1:0] nm_code, win_vec;
    logic [IDXW-1:0] m_idx;
    logic [PSW-1:0]  psel_q;
    logic            take_q;
    logic [VECW-1:0] vec_q;

    irq_nm_pick #(.VECW(VECW)) u_nm (
        .hp_req(hp_req), .x_mask(x_mask), .illop_req(illop_req),
        .swtrap_req(swtrap_req), .hit(nm_hit), .code(nm_code)
    );

    irq_mask_pick #(.N_SRC(N_SRC), .PSW(PSW), .IDXW(IDXW)) u_mask (
        .flag(src_flag), .en(src_en), .blocked(i_mask),
        .psel(psel_q), .hit(m_hit), .idx(m_idx)
    );

    // Non-maskable winner outranks any maskable winner.
    always_comb begin
        if (nm_hit)     win_vec = nm_code;
        else if (m_hit) win_vec = VECW'(VEC_MBASE) + VECW'(m_idx);
        else            win_vec = VECW'(VEC_NONE);
    end

    assign take_now = boundary && (nm_hit || m_hit);
    assign take_hp  = take_now && nm_hit && (nm_code == VECW'(VEC_HP));

    irq_ccr_regs #(.PSW(PSW)) u_ccr (
        .clk(clk), .rst_n(rst_n), .take_now(take_now), .take_hp(take_hp),
        .rti(rti), .rti_i(rti_i), .rti_x(rti_x), .set_i(set_i),
        .clr_i(clr_i), .clr_x(clr_x), .psel_wr(psel_wr),
        .psel_data(psel_data), .i_q(i_mask), .x_q(x_mask), .psel_q(psel_q)
    );

    // Register strobe and vector; both idle at zero when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n || !take_now) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= 1'b1;
            vec_q  <= win_vec;
        end
    end

    assign take = take_q;
    assign vec  = vec_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
// Temporal checks on the arbiter, bound into every instance of the top.
// Assumes it sees the top's ports and its internal priority-select register.
module irq_arbiter_chk #(
    parameter int VECW = 5,
    parameter int PSW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boundary,
    input logic            take,
    input logic [VECW-1:0] vec,
    input logic            i_mask,
    input logic            x_mask,
    input logic [PSW-1:0]  psel_q
);
    // R2
    take_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));
    // R2
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (vec == '0));
    // R2
    take_vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vec != '0));
    // R11
    entry_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> i_mask);
    // R12
    x_rise_only_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_mask) |-> (take && vec == VECW'(1)));
    // R4
    hp_needs_x_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec == VECW'(1)) |-> !$past(x_mask));
    // R6
    mask_needs_i_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec >= VECW'(4)) |-> !$past(i_mask));
    // R10
    psel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(i_mask) |-> $stable(psel_q));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VECW(VECW), .PSW(PSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .take(take), .vec(vec),
    .i_mask(i_mask), .x_mask(x_mask), .psel_q(psel_q)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
    localparam int N    = 13;
    localparam int PSW  = 4;
    localparam int VECW = $clog2(N + 4);

    logic clk = 0, rst_n = 0;
    logic boundary, hp_req, illop_req, swtrap_req;
    logic [N-1:0] src_flag, src_en;
    logic rti, rti_i, rti_x, set_i, clr_i, clr_x, psel_wr;
    logic [PSW-1:0] psel_data;
    logic take, i_mask, x_mask;
    logic [VECW-1:0] vec;

    int total = 0, bad = 0;
    bit done = 0;

    // Reference model state
    int m_take = 0, m_vec = 0, m_i = 1, m_x = 1, m_psel = 0;

    always #2.5 clk = ~clk;

    irq_arbiter #(.N_SRC(N), .PSW(PSW)) uut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .hp_req(hp_req),
        .illop_req(illop_req), .swtrap_req(swtrap_req), .src_flag(src_flag),
        .src_en(src_en), .rti(rti), .rti_i(rti_i), .rti_x(rti_x),
        .set_i(set_i), .clr_i(clr_i), .clr_x(clr_x), .psel_wr(psel_wr),
        .psel_data(psel_data), .take(take), .vec(vec), .i_mask(i_mask),
        .x_mask(x_mask)
    );

    // Behavioural reference: the next state is computed from the requirements text.
    always @(posedge clk) begin
        int w, ni, nx, np;
        if (!rst_n) begin
            m_take = 0; m_vec = 0; m_i = 1; m_x = 1; m_psel = 0;
        end else begin
            w = 0;
            if (boundary) begin
                if (hp_req && m_x == 0) w = 1;
                else if (illop_req) w = 2;
                else if (swtrap_req) w = 3;
                else if (m_i == 0) begin
                    if (m_psel < N && src_flag[m_psel] && src_en[m_psel]) w = 4 + m_psel;
                    else for (int k = N - 1; k >= 0; k--)
                        if (src_flag[k] && src_en[k]) w = 4 + k;
                end
            end
            ni = m_i; nx = m_x; np = m_psel;
            if (w != 0) ni = 1;
            else if (rti) ni = rti_i;
            else if (set_i) ni = 1;
            else if (clr_i) ni = 0;
            if (w == 1) nx = 1;
            else if (rti) nx = m_x & rti_x;
            else if (clr_x) nx = 0;
            if (psel_wr && m_i == 1) np = psel_data;
            m_take = (w != 0); m_vec = w; m_i = ni; m_x = nx; m_psel = np;
        end
    end

    // R2: compare every cycle against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (take !== m_take[0] || vec !== VECW'(m_vec) ||
                i_mask !== m_i[0] || x_mask !== m_x[0]) begin
                bad++;
                $display("FAIL R2 model compare: take=%0d vec=%0d i=%0d x=%0d expected take=%0d vec=%0d i=%0d x=%0d",
                         take, vec, i_mask, x_mask, m_take, m_vec, m_i, m_x);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        boundary = 0; hp_req = 0; illop_req = 0; swtrap_req = 0;
        src_flag = '0; src_en = '0; rti = 0; rti_i = 0; rti_x = 0;
        set_i = 0; clr_i = 0; clr_x = 0; psel_wr = 0; psel_data = '0;
    endtask

    // Apply the current inputs across one edge, then return to idle at the negedge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 take", take, 0); chk("R1 vec", vec, 0);
        chk("R1 i_mask", i_mask, 1); chk("R1 x_mask", x_mask, 1);

        // R4 pin masked while X=1
        boundary = 1; hp_req = 1; cyc();
        chk("R4 pin ignored with X set", take, 0);
        // R5 software trap taken with I and X set
        boundary = 1; hp_req = 1; swtrap_req = 1; cyc();
        chk("R5 swtrap vec", vec, 3);

        clr_x = 1; cyc();
        chk("R12 clr_x", x_mask, 0);
        // R3 order: pin over illegal over software
        boundary = 1; hp_req = 1; illop_req = 1; swtrap_req = 1; cyc();
        chk("R3 pin wins", vec, 1);
        chk("R12 X set on pin take", x_mask, 1);
        boundary = 1; illop_req = 1; swtrap_req = 1; cyc();
        chk("R3 illegal over swtrap", vec, 2);

        // R10: write while I=1 (5) accepted, write while I=0 (7) ignored
        psel_wr = 1; psel_data = 4'd5; cyc();
        clr_i = 1; cyc();
        chk("R11 clr_i", i_mask, 0);
        psel_wr = 1; psel_data = 4'd7; cyc();

        // R7: enable needed; source 9 flagged but disabled, 11 wins
        boundary = 1; src_flag = 13'h0A00; src_en = 13'h0800; cyc();
        chk("R7 enabled source vec", vec, 15);
        chk("R11 I set on entry", i_mask, 1);

        clr_x = 1; cyc();
        rti = 1; rti_i = 0; rti_x = 1; cyc();
        chk("R11 rti restores I", i_mask, 0);
        chk("R12 rti cannot set X", x_mask, 0);

        // R8 lowest index wins (psel=5 not pending)
        boundary = 1; src_flag = 13'h0108; src_en = '1; cyc();
        chk("R8 lowest index", vec, 7);
        rti = 1; cyc();
        // R9 promotion of 5, R10 proves 7 was rejected
        boundary = 1; src_flag = 13'h00A8; src_en = '1; cyc();
        chk("R9 promoted source", vec, 9);
        chk("R10 write with I clear ignored", vec, 9);
        rti = 1; cyc();

        // R6 block and release
        set_i = 1; cyc();
        chk("R11 set_i", i_mask, 1);
        boundary = 1; src_flag = 13'h0004; src_en = '1; cyc();
        chk("R6 blocked while I set", take, 0);
        clr_i = 1; cyc();
        boundary = 1; src_flag = 13'h0004; src_en = '1; cyc();
        chk("R6 taken after clear", vec, 6);

        rti = 1; cyc();
        src_flag = 13'h0002; src_en = '1; cyc();
        chk("R2 no boundary no take", take, 0);
        chk("R2 idle vec zero", vec, 0);

        // R9 out-of-range select promotes nothing
        set_i = 1; cyc();
        psel_wr = 1; psel_data = 4'd15; cyc();
        clr_i = 1; cyc();
        boundary = 1; src_flag = 13'h1010; src_en = '1; cyc();
        chk("R9 out-of-range select", vec, 8);

        // Random phase checked by the model only
        for (int n = 0; n < 600; n++) begin
            boundary = ($urandom % 2) == 0;
            hp_req = ($urandom % 6) == 0;
            illop_req = ($urandom % 12) == 0;
            swtrap_req = ($urandom % 12) == 0;
            src_flag = N'($urandom);
            src_en = N'($urandom);
            rti = ($urandom % 5) == 0;
            rti_i = ($urandom % 3) == 0;
            rti_x = $urandom % 2;
            set_i = ($urandom % 8) == 0;
            clr_i = ($urandom % 4) == 0;
            clr_x = ($urandom % 6) == 0;
            psel_wr = ($urandom % 6) == 0;
            psel_data = PSW'($urandom);
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule